// File: doc/BRIEF.md
# Hardwired Control Signal Generator

This block is the combinational heart of a hardwired control unit. A phase sequencer elsewhere supplies four inputs. The first is a two-bit cycle phase code. The second is a one-hot time slot within that phase. The third is a direct-address bit, and the fourth is a set of one-hot decoded opcode lines. Each time slot lasts one clock cycle. For each combination of these inputs, the block raises the gate enables that move data between the program counter, instruction register, memory address register, memory buffer register, accumulator, the ALU, and the external address and data buses. It also drives the memory read and write strobes and the ALU increment and add selects.

The block covers three sequences:
- the instruction fetch, with the direct-address operand load that follows it;
- the indirect-address phase;
- the add-to-memory execute sequence.

In the fetch sequence, the program-counter increment is folded into the memory-read slot. The increment passes through the ALU and is parked in the accumulator. It is then copied back to the program counter in the slot that loads the instruction register. Every slot in which no transfer is defined yields all enables low.

Top module: `hwctl_gen`

## Requirements
- R1: In phase 00 (fetch), slot t1 (slot bit 0), only `pcToMar` is high.
- R2: In fetch slot t2 (slot bit 1), exactly these enables are high: `marToAbus`, `memRd`, `dbusToMbr`, `pcToAlu`, `aluInc` and `aluToAc`.
- R3: In fetch slot t3 (slot bit 2), exactly `acToPc` and `mbrToIr` are high, together.
- R4: In fetch with `directBit`=1, slot t4 (bit 3) raises only `irToMar`, and slot t5 (bit 4) raises exactly `marToAbus`, `memRd` and `dbusToMbr`. With `directBit`=0, both slots are silent.
- R5: In phase 01 (indirect), the slots raise the following, and nothing else:
  - t1: `irToMar`;
  - t2: the read set (`marToAbus`, `memRd`, `dbusToMbr`);
  - t3: `mbrToMar`;
  - t4: the read set again.
- R6: In phase 10 (execute), with only the add opcode line (`opLines` bit `ADD_OP`, default 0) high, the slots raise the following, and nothing else:
  - t1: `mbrToAlu`, `acToAlu` and `aluAdd`;
  - t2: `aluToAc`;
  - t3: `acToMbr` and `irToMar`;
  - t4: `marToAbus`, `mbrToDbus` and `memWr`.
- R7: In execute, if the opcode lines are not exactly the add line (another single line, no line, or several lines), all enables are low.
- R8: If the time-slot input does not have exactly one bit set, all enables are low.
- R9: All enables are low in slot t6 and higher in every phase, in slots t5 and t6 of execute and indirect, and in every slot of phase 11.
- R10: `memRd` and `memWr` are never high together, and either strobe is high only while `marToAbus` is high.
- R11: No register is both a source and a destination in one slot. This holds for MBR, AC, MAR and PC.
- R12: Applying the enables to a register-transfer model of the datapath gives the expected results:
  - a fetch followed by a direct operand load and an add leaves memory[X] = operand + AC, loads IR, and increments PC;
  - an indirect fetch loads MBR with the word at the pointed-to address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase | input | 2 | Cycle phase: 00 fetch, 01 indirect, 10 execute, 11 interrupt |
| slot | input | NUM_SLOTS | One-hot time slot, bit 0 = t1 |
| directBit | input | 1 | 1 = operand address in IR is direct |
| opLines | input | NUM_OPS | One-hot decoded opcode lines |
| pcToMar | output | 1 | Gate PC into MAR |
| marToAbus | output | 1 | Gate MAR onto the address bus |
| memRd | output | 1 | Memory read strobe |
| dbusToMbr | output | 1 | Gate data bus into MBR |
| pcToAlu | output | 1 | Gate PC into the ALU |
| aluInc | output | 1 | ALU increment function |
| aluToAc | output | 1 | Gate ALU result into AC |
| acToPc | output | 1 | Gate AC into PC |
| mbrToIr | output | 1 | Gate MBR into IR |
| irToMar | output | 1 | Gate IR address field into MAR |
| mbrToMar | output | 1 | Gate MBR into MAR |
| mbrToAlu | output | 1 | Gate MBR into the ALU |
| acToAlu | output | 1 | Gate AC into the ALU |
| aluAdd | output | 1 | ALU add function |
| acToMbr | output | 1 | Gate AC into MBR |
| mbrToDbus | output | 1 | Gate MBR onto the data bus |
| memWr | output | 1 | Memory write strobe |

## Verification
Several properties are checked on every input change, whatever the stimulus:
- read and write are mutually exclusive;
- a memory strobe always comes with the address-bus gate;
- no register is read and written in the same slot;
- the outputs fall silent when the slot is not one-hot.

The exact enable set of each phase and slot is covered only by the bench's scenarios. So are the dependence on the direct bit and the rejection of stray opcodes. Whether the slot ordering actually moves the right data is shown only by driving a register-transfer model of the datapath through whole instructions.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

  // Phase encoding: bit 1 and bit 0 are the two state bits of the cycle code.
  typedef enum logic [1:0] {
    PH_FETCH     = 2'b00,
    PH_INDIRECT  = 2'b01,
    PH_EXECUTE   = 2'b10,
    PH_INTERRUPT = 2'b11
  } phase_e;

  // Number of time slots that carry any transfer (t1..t5).
  localparam int USED_SLOTS = 5;

  // Strobe bundle from the term logic to the top.
  typedef struct packed {
    logic pcToMar;
    logic marToAbus;
    logic memRd;
    logic dbusToMbr;
    logic pcToAlu;
    logic aluInc;
    logic aluToAc;
    logic acToPc;
    logic mbrToIr;
    logic irToMar;
    logic mbrToMar;
    logic mbrToAlu;
    logic acToAlu;
    logic aluAdd;
    logic acToMbr;
    logic mbrToDbus;
    logic memWr;
  } gates_t;

  // Qualified phase flags handed to the term logic.
  typedef struct packed {
    logic inFetch;
    logic inIndirect;
    logic inExecAdd;
    logic direct;
  } qual_t;

endpackage

// File: rtl/onehot_chk.sv
module onehot_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  output logic         isOne
);

  logic seen;
  logic dup;

  always_comb begin
    seen = 1'b0;
    dup  = 1'b0;
    for (int i = 0; i < W; i++) begin
      dup  = dup | (seen & vec[i]);
      seen = seen | vec[i];
    end
    isOne = seen & ~dup;
  end

endmodule

// File: rtl/cu_qualify.sv
module cu_qualify
  import hwctl_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_OPS   = 8,
  parameter int ADD_OP    = 0
) (
  input  logic [1:0]            phaseIn,
  input  logic [NUM_SLOTS-1:0]  slotIn,
  input  logic                  directIn,
  input  logic [NUM_OPS-1:0]    opIn,
  output qual_t                 qual,
  output logic [USED_SLOTS-1:0] tSel,
  output logic                  slotOk
);

  localparam int LOW_SLOTS = (NUM_SLOTS < USED_SLOTS) ? NUM_SLOTS : USED_SLOTS;

  logic opOk;
  logic addSel;

  onehot_chk #(.W(NUM_SLOTS)) uSlotChk (.vec(slotIn), .isOne(slotOk));
  onehot_chk #(.W(NUM_OPS))   uOpChk   (.vec(opIn),   .isOne(opOk));

  assign addSel = opOk & opIn[ADD_OP];

  // Slots beyond the parameterised range read as inactive.
  generate
    if (LOW_SLOTS < USED_SLOTS) begin : g_pad
      assign tSel = slotOk ? {{(USED_SLOTS-LOW_SLOTS){1'b0}}, slotIn[LOW_SLOTS-1:0]}
                           : '0;
    end else begin : g_direct
      assign tSel = slotOk ? slotIn[USED_SLOTS-1:0] : '0;
    end
  endgenerate

  always_comb begin
    qual            = '0;
    qual.inFetch    = (phase_e'(phaseIn) == PH_FETCH);
    qual.inIndirect = (phase_e'(phaseIn) == PH_INDIRECT);
    qual.inExecAdd  = (phase_e'(phaseIn) == PH_EXECUTE) & addSel;
    qual.direct     = directIn;
  end

endmodule

// File: rtl/cu_gate_terms.sv
module cu_gate_terms
  import hwctl_pkg::*;
(
  input  qual_t                 qual,
  input  logic [USED_SLOTS-1:0] tSel,
  output gates_t                gates
);

  localparam int T1 = 0;
  localparam int T2 = 1;
  localparam int T3 = 2;
  localparam int T4 = 3;
  localparam int T5 = 4;

  logic fe, ind, ex, dr;
  logic rdSlot;

  assign fe  = qual.inFetch;
  assign ind = qual.inIndirect;
  assign ex  = qual.inExecAdd;
  assign dr  = qual.direct;

  // Slots in which a memory read is performed into MBR.
  assign rdSlot = (fe  & (tSel[T2] | (dr & tSel[T5])))
                | (ind & (tSel[T2] | tSel[T4]));

  always_comb begin
    gates           = '0;
    gates.pcToMar   = fe & tSel[T1];
    gates.memRd     = rdSlot;
    gates.dbusToMbr = rdSlot;
    gates.marToAbus = rdSlot | (ex & tSel[T4]);
    gates.pcToAlu   = fe & tSel[T2];
    gates.aluInc    = fe & tSel[T2];
    gates.aluToAc   = (fe & tSel[T2]) | (ex & tSel[T2]);
    gates.acToPc    = fe & tSel[T3];
    gates.mbrToIr   = fe & tSel[T3];
    gates.irToMar   = (fe & dr & tSel[T4]) | (ind & tSel[T1]) | (ex & tSel[T3]);
    gates.mbrToMar  = ind & tSel[T3];
    gates.mbrToAlu  = ex & tSel[T1];
    gates.acToAlu   = ex & tSel[T1];
    gates.aluAdd    = ex & tSel[T1];
    gates.acToMbr   = ex & tSel[T3];
    gates.mbrToDbus = ex & tSel[T4];
    gates.memWr     = ex & tSel[T4];
  end

  always_comb begin
    if (!$isunknown(gates)) begin
      AST_RD_WR_EXCL: assert (!(gates.memRd && gates.memWr))
        else $error("read and write strobes together"); // R10
      AST_STROBE_HAS_ADDR: assert (!(gates.memRd || gates.memWr) || gates.marToAbus)
        else $error("memory strobe without address gate"); // R10
      AST_MBR_NO_RW: assert (!((gates.dbusToMbr || gates.acToMbr) &&
                               (gates.mbrToIr || gates.mbrToMar || gates.mbrToAlu || gates.mbrToDbus)))
        else $error("MBR read and written in one slot"); // R11
      AST_AC_NO_RW: assert (!(gates.aluToAc && (gates.acToPc || gates.acToAlu || gates.acToMbr)))
        else $error("AC read and written in one slot"); // R11
      AST_MAR_NO_RW: assert (!((gates.pcToMar || gates.irToMar || gates.mbrToMar) && gates.marToAbus))
        else $error("MAR read and written in one slot"); // R11
      AST_PC_NO_RW: assert (!(gates.acToPc && (gates.pcToMar || gates.pcToAlu)))
        else $error("PC read and written in one slot"); // R11
    end
  end

endmodule

// File: rtl/hwctl_gen.sv
module hwctl_gen
  import hwctl_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_OPS   = 8,
  parameter int ADD_OP    = 0
) (
  input  logic [1:0]           phase,
  input  logic [NUM_SLOTS-1:0] slot,
  input  logic                 directBit,
  input  logic [NUM_OPS-1:0]   opLines,
  output logic                 pcToMar,
  output logic                 marToAbus,
  output logic                 memRd,
  output logic                 dbusToMbr,
  output logic                 pcToAlu,
  output logic                 aluInc,
  output logic                 aluToAc,
  output logic                 acToPc,
  output logic                 mbrToIr,
  output logic                 irToMar,
  output logic                 mbrToMar,
  output logic                 mbrToAlu,
  output logic                 acToAlu,
  output logic                 aluAdd,
  output logic                 acToMbr,
  output logic                 mbrToDbus,
  output logic                 memWr
);

  qual_t                 qual;
  logic [USED_SLOTS-1:0] tSel;
  logic                  slotOk;
  gates_t                gates;

  cu_qualify #(
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_OPS  (NUM_OPS),
    .ADD_OP   (ADD_OP)
  ) uQualify (
    .phaseIn (phase),
    .slotIn  (slot),
    .directIn(directBit),
    .opIn    (opLines),
    .qual    (qual),
    .tSel    (tSel),
    .slotOk  (slotOk)
  );

  cu_gate_terms uTerms (
    .qual (qual),
    .tSel (tSel),
    .gates(gates)
  );

  assign pcToMar   = gates.pcToMar;
  assign marToAbus = gates.marToAbus;
  assign memRd     = gates.memRd;
  assign dbusToMbr = gates.dbusToMbr;
  assign pcToAlu   = gates.pcToAlu;
  assign aluInc    = gates.aluInc;
  assign aluToAc   = gates.aluToAc;
  assign acToPc    = gates.acToPc;
  assign mbrToIr   = gates.mbrToIr;
  assign irToMar   = gates.irToMar;
  assign mbrToMar  = gates.mbrToMar;
  assign mbrToAlu  = gates.mbrToAlu;
  assign acToAlu   = gates.acToAlu;
  assign aluAdd    = gates.aluAdd;
  assign acToMbr   = gates.acToMbr;
  assign mbrToDbus = gates.mbrToDbus;
  assign memWr     = gates.memWr;

  always_comb begin
    if (!$isunknown(slot) && !$isunknown(gates)) begin
      AST_SLOT_SILENT: assert (slotOk || (gates == '0))
        else $error("enables raised on a malformed slot"); // R8
    end
  end

endmodule

// File: tb/tb_hwctl_gen.sv
module tb_hwctl_gen;

  localparam int NS    = 6;
  localparam int NO    = 8;
  localparam int ADDOP = 0;

  // Bit masks of the observed enable vector, MSB first in port order.
  localparam logic [16:0] M_PC2MAR  = 17'(1) << 16;
  localparam logic [16:0] M_MAR2AB  = 17'(1) << 15;
  localparam logic [16:0] M_MEMRD   = 17'(1) << 14;
  localparam logic [16:0] M_DB2MBR  = 17'(1) << 13;
  localparam logic [16:0] M_PC2ALU  = 17'(1) << 12;
  localparam logic [16:0] M_INC     = 17'(1) << 11;
  localparam logic [16:0] M_ALU2AC  = 17'(1) << 10;
  localparam logic [16:0] M_AC2PC   = 17'(1) << 9;
  localparam logic [16:0] M_MBR2IR  = 17'(1) << 8;
  localparam logic [16:0] M_IR2MAR  = 17'(1) << 7;
  localparam logic [16:0] M_MBR2MAR = 17'(1) << 6;
  localparam logic [16:0] M_MBR2ALU = 17'(1) << 5;
  localparam logic [16:0] M_AC2ALU  = 17'(1) << 4;
  localparam logic [16:0] M_ADD     = 17'(1) << 3;
  localparam logic [16:0] M_AC2MBR  = 17'(1) << 2;
  localparam logic [16:0] M_MBR2DB  = 17'(1) << 1;
  localparam logic [16:0] M_MEMWR   = 17'(1) << 0;
  localparam logic [16:0] RD_SET    = M_MAR2AB | M_MEMRD | M_DB2MBR;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]    phase     = '0;
  logic [NS-1:0] slot      = '0;
  logic          directBit = 1'b0;
  logic [NO-1:0] opLines   = '0;

  logic pcToMar, marToAbus, memRd, dbusToMbr, pcToAlu, aluInc, aluToAc, acToPc;
  logic mbrToIr, irToMar, mbrToMar, mbrToAlu, acToAlu, aluAdd, acToMbr, mbrToDbus, memWr;

  hwctl_gen #(.NUM_SLOTS(NS), .NUM_OPS(NO), .ADD_OP(ADDOP)) dut (
    .phase(phase), .slot(slot), .directBit(directBit), .opLines(opLines),
    .pcToMar(pcToMar), .marToAbus(marToAbus), .memRd(memRd), .dbusToMbr(dbusToMbr),
    .pcToAlu(pcToAlu), .aluInc(aluInc), .aluToAc(aluToAc), .acToPc(acToPc),
    .mbrToIr(mbrToIr), .irToMar(irToMar), .mbrToMar(mbrToMar), .mbrToAlu(mbrToAlu),
    .acToAlu(acToAlu), .aluAdd(aluAdd), .acToMbr(acToMbr), .mbrToDbus(mbrToDbus),
    .memWr(memWr)
  );

  logic [16:0] obs;
  assign obs = {pcToMar, marToAbus, memRd, dbusToMbr, pcToAlu, aluInc, aluToAc, acToPc,
                mbrToIr, irToMar, mbrToMar, mbrToAlu, acToAlu, aluAdd, acToMbr, mbrToDbus, memWr};

  int  numChecks = 0;
  int  numFails  = 0;
  bit  finished  = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (!ok) begin
      numFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected enables derived from the requirement list.
  function automatic logic [16:0] refGates(input logic [1:0] ph, input logic [NS-1:0] sl,
                                           input logic d, input logic [NO-1:0] op);
    int t;
    bit addOnly;
    logic [16:0] e;
    t = -1;
    e = '0;
    if ($countones(sl) == 1)
      for (int i = 0; i < NS; i++) if (sl[i]) t = i;
    addOnly = ($countones(op) == 1) && op[ADDOP];
    case (ph)
      2'b00: case (t)
        0: e = M_PC2MAR;
        1: e = RD_SET | M_PC2ALU | M_INC | M_ALU2AC;
        2: e = M_AC2PC | M_MBR2IR;
        3: e = d ? M_IR2MAR : '0;
        4: e = d ? RD_SET : '0;
        default: e = '0;
      endcase
      2'b01: case (t)
        0: e = M_IR2MAR;
        1: e = RD_SET;
        2: e = M_MBR2MAR;
        3: e = RD_SET;
        default: e = '0;
      endcase
      2'b10: if (addOnly) case (t)
        0: e = M_MBR2ALU | M_AC2ALU | M_ADD;
        1: e = M_ALU2AC;
        2: e = M_AC2MBR | M_IR2MAR;
        3: e = M_MAR2AB | M_MBR2DB | M_MEMWR;
        default: e = '0;
      endcase
      default: e = '0;
    endcase
    return e;
  endfunction

  // Scoreboard
  typedef struct {
    logic [16:0] exp;
    string       tag;
  } sbItem_t;
  sbItem_t sbq[$];

  task automatic apply(input logic [1:0] ph, input int t, input logic d,
                       input logic [NO-1:0] op, input string tag);
    sbItem_t it;
    @(negedge clk);
    phase     = ph;
    slot      = (t >= 1 && t <= NS) ? NS'(1) << (t - 1) : '0;
    directBit = d;
    opLines   = op;
    it.exp    = refGates(ph, slot, d, op);
    it.tag    = tag;
    sbq.push_back(it);
  endtask

  task automatic applyRaw(input logic [1:0] ph, input logic [NS-1:0] sl,
                          input logic [NO-1:0] op, input string tag);
    sbItem_t it;
    @(negedge clk);
    phase     = ph;
    slot      = sl;
    directBit = 1'b1;
    opLines   = op;
    it.exp    = refGates(ph, sl, 1'b1, op);
    it.tag    = tag;
    sbq.push_back(it);
  endtask

  initial begin
    forever begin
      sbItem_t it;
      @(negedge clk);
      #5;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(obs == it.exp, it.tag, 32'(obs), 32'(it.exp));
        check(!(memRd && memWr) && (!(memRd || memWr) || marToAbus),
              "R10 strobe rules", 32'(obs), 32'(0));
        check(!((dbusToMbr || acToMbr) && (mbrToIr || mbrToMar || mbrToAlu || mbrToDbus)) &&
              !(aluToAc && (acToPc || acToAlu || acToMbr)),
              "R11 no read-write same slot", 32'(obs), 32'(0));
      end
    end
  end

  // Register-transfer model of the datapath, driven by the enables.
  bit         modelOn = 1'b0;
  logic [7:0] pc, mar, mbr, ir, ac, aluBuf;
  logic [7:0] mem [16];
  logic [7:0] aluNow;
  logic       aluActive;

  always_comb begin
    aluActive = 1'b1;
    if (pcToAlu && aluInc)                   aluNow = pc + 8'd1;
    else if (mbrToAlu && acToAlu && aluAdd)  aluNow = mbr + ac;
    else begin
      aluNow    = aluBuf;
      aluActive = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!modelOn) begin
      pc <= 8'h00; mar <= 8'h00; mbr <= 8'h00; ir <= 8'h00; ac <= 8'h30; aluBuf <= 8'h00;
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      mem[0] <= 8'h05; mem[5] <= 8'h12;
      mem[1] <= 8'h06; mem[6] <= 8'h09; mem[9] <= 8'h20;
    end else begin
      if (aluActive) aluBuf <= aluNow;
      if (aluToAc) ac <= aluNow;
      if (acToPc)  pc <= ac;
      if (mbrToIr) ir <= mbr;
      if (pcToMar)       mar <= pc;
      else if (irToMar)  mar <= {4'h0, ir[3:0]};
      else if (mbrToMar) mar <= mbr;
      if (memRd && marToAbus && dbusToMbr) mbr <= mem[mar[3:0]];
      else if (acToMbr)                    mbr <= ac;
      if (memWr && marToAbus && mbrToDbus) mem[mar[3:0]] <= mbr;
    end
  end

  localparam logic [NO-1:0] OP_ADD   = NO'(1) << ADDOP;
  localparam logic [NO-1:0] OP_OTHER = NO'(1) << 3;

  initial begin
    repeat (3) @(negedge clk);
    // Idle state with all inputs low
    apply(2'b00, 0, 1'b0, '0, "R8 idle all-low");
    // Fetch
    apply(2'b00, 1, 1'b1, '0, "R1 fetch t1");
    apply(2'b00, 2, 1'b1, '0, "R2 fetch t2");
    apply(2'b00, 3, 1'b0, '0, "R3 fetch t3");
    apply(2'b00, 4, 1'b1, '0, "R4 fetch t4 direct");
    apply(2'b00, 5, 1'b1, '0, "R4 fetch t5 direct");
    apply(2'b00, 4, 1'b0, '0, "R4 fetch t4 indirect silent");
    apply(2'b00, 5, 1'b0, '0, "R4 fetch t5 indirect silent");
    apply(2'b00, 6, 1'b1, '0, "R9 fetch t6");
    // Indirect
    for (int t = 1; t <= 6; t++) apply(2'b01, t, 1'b0, OP_ADD, $sformatf("R5 indirect t%0d", t));
    // Execute add
    for (int t = 1; t <= 6; t++) apply(2'b10, t, 1'b0, OP_ADD, $sformatf("R6 execute add t%0d", t));
    // Other opcodes
    for (int t = 1; t <= 4; t++) apply(2'b10, t, 1'b0, OP_OTHER, "R7 other opcode");
    apply(2'b10, 1, 1'b0, '0, "R7 no opcode");
    apply(2'b10, 4, 1'b0, OP_ADD | OP_OTHER, "R7 two opcodes");
    // Malformed slots
    applyRaw(2'b00, 6'b000011, '0, "R8 two slot bits fetch");
    applyRaw(2'b10, 6'b001100, OP_ADD, "R8 two slot bits execute");
    applyRaw(2'b01, 6'b111111, '0, "R8 all slot bits");
    // Interrupt phase
    for (int t = 1; t <= 6; t++) apply(2'b11, t, 1'b1, OP_ADD, "R9 interrupt phase silent");

    // R12: whole instructions through the datapath model
    @(negedge clk);
    modelOn = 1'b1;
    apply(2'b00, 1, 1'b1, '0, "R12 run fetch t1");
    apply(2'b00, 2, 1'b1, '0, "R12 run fetch t2");
    apply(2'b00, 3, 1'b1, '0, "R12 run fetch t3");
    apply(2'b00, 4, 1'b1, '0, "R12 run direct t4");
    apply(2'b00, 5, 1'b1, '0, "R12 run direct t5");
    for (int t = 1; t <= 4; t++) apply(2'b10, t, 1'b0, OP_ADD, "R12 run exec");
    apply(2'b00, 0, 1'b0, '0, "R12 idle");
    check(pc == 8'h01, "R12 PC after fetch", 32'(pc), 32'h01);
    check(ir == 8'h05, "R12 IR loaded", 32'(ir), 32'h05);
    check(ac == 8'h13, "R12 AC sum", 32'(ac), 32'h13);
    check(mem[5] == 8'h13, "R12 memory sum stored", 32'(mem[5]), 32'h13);

    apply(2'b00, 1, 1'b0, '0, "R12 run2 fetch t1");
    apply(2'b00, 2, 1'b0, '0, "R12 run2 fetch t2");
    apply(2'b00, 3, 1'b0, '0, "R12 run2 fetch t3");
    for (int t = 1; t <= 4; t++) apply(2'b01, t, 1'b0, '0, "R12 run2 indirect");
    apply(2'b00, 0, 1'b0, '0, "R12 idle");
    check(mbr == 8'h20, "R12 indirect operand in MBR", 32'(mbr), 32'h20);
    check(mar == 8'h09, "R12 indirect pointer in MAR", 32'(mar), 32'h09);
    check(pc == 8'h02, "R12 PC second fetch", 32'(pc), 32'h02);
    for (int t = 1; t <= 4; t++) apply(2'b10, t, 1'b0, OP_ADD, "R12 run2 exec");
    apply(2'b00, 0, 1'b0, '0, "R12 idle");
    check(ac == 8'h22, "R12 AC second sum", 32'(ac), 32'h22);
    check(mem[6] == 8'h22, "R12 second store", 32'(mem[6]), 32'h22);
    check(mem[9] == 8'h20, "R12 operand cell untouched", 32'(mem[9]), 32'h20);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!finished) begin
      finished = 1'b1;
      numChecks++;
      numFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
      $finish;
    end
  end

endmodule